// File: doc/BRIEF.md
# External Trigger Input Conditioner

This block turns an asynchronous trigger pin into a clean level and a count-enable strobe for a general-purpose timer. The pin is synchronized, optionally inverted, divided in edge rate by a prescaler, and then passed through a digital filter. The filter samples at a programmable fraction of the peripheral clock and only moves its output once a required number of consecutive samples agree on the new level. A final edge detector produces a one-cycle pulse on each rising edge of the filtered level. The timer uses that pulse to advance its counter when external clocking is selected.

All configuration inputs are plain control pins sampled every cycle. There is no data stream at the edge of the block, so there is no valid/ready handshake. The strobe is a single-cycle pulse that the timer must take in the cycle it appears. After the prescaler, the active signal must change no faster than once per four clock cycles, or edges may be lost. The two synchronizer flops and the prescaler's edge-history flop keep sampling while reset is asserted. This lets the idle pin level settle before reset is released.

Top module: `ext_trig_cond`

## Requirements
- R1: While reset is asserted and after its release with the pin idle, `trig_filt` and `cnt_en` are 0.
- R2: `inv_pol`=0 makes a high pin level active, so rising pin edges count. `inv_pol`=1 makes a low level active, so falling pin edges count.
- R3: `psc_sel` picks an edge divide ratio of 1, 2, 4 or 8 (codes 0..3). For ratio M>1, the prescaled level first rises after M/2 active edges and then once per M edges. After E edges from a clear, its level is 1 when (E mod M) >= M/2. For ratio 1 it follows the active level.
- R4: Any change of `psc_sel` clears the prescaler's edge count, so counting restarts from zero edges.
- R5: Filter code 0 applies no filtering. An active pin change reaches `trig_filt` 4 clock edges after it is driven.
- R6: The filter output changes only after N consecutive samples differ from it. With sampling at the full clock rate, latency is exactly 3+N edges, and a pulse shorter than N cycles is rejected.
- R7: The codes give these (divider D, count N) pairs: 0:(1,1) 1:(1,2) 2:(1,4) 3:(1,8) 4:(2,6) 5:(2,8) 6:(4,6) 7:(4,8) 8:(8,6) 9:(8,8) 10:(16,5) 11:(16,6) 12:(16,8) 13:(32,5) 14:(32,6) 15:(32,8). The rise latency lies in [4+(N-1)D, 3+ND].
- R8: With `ext_clk_en`=1, every rising edge of `trig_filt` gives exactly one single-cycle `cnt_en` pulse.
- R9: With `ext_clk_en`=0, `cnt_en` stays 0 while `trig_filt` still follows the input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig_pin | input | 1 | Asynchronous raw trigger pin |
| inv_pol | input | 1 | 1 selects low level / falling edge as active |
| psc_sel | input | 2 | Edge prescaler code |
| flt_sel | input | 4 | Filter sampling-rate and sample-count code |
| ext_clk_en | input | 1 | Enables count pulses from the filtered trigger |
| trig_filt | output | 1 | Filtered trigger level |
| cnt_en | output | 1 | One-cycle count-enable strobe |

## Verification
The embedded properties check on every cycle that:
- the filter output only moves on a sampling tick;
- the agreement counter never exceeds its limit;
- a prescaler code change empties the edge count;
- every strobe is single-cycle, sits on a fresh rise of the filtered level, and is absent when external clocking is off.

Only the bench scenarios can show the rest: the exact rise latency for each filter code, rejection of a pulse one cycle shorter than required, the divide ratios, and the correct strobe count after a train of edges under both polarities.

// File: rtl/etc_pkg.sv
package etc_pkg;
  localparam int PSC_W     = 2;
  localparam int FLT_W     = 4;
  localparam int MAX_SHIFT = 5;
  localparam int EV_W      = 3;

  function automatic logic [2:0] flt_shift(input logic [FLT_W-1:0] code);
    case (code)
      4'd0, 4'd1, 4'd2, 4'd3:    flt_shift = 3'd0;
      4'd4, 4'd5:                flt_shift = 3'd1;
      4'd6, 4'd7:                flt_shift = 3'd2;
      4'd8, 4'd9:                flt_shift = 3'd3;
      4'd10, 4'd11, 4'd12:       flt_shift = 3'd4;
      default:                   flt_shift = 3'd5;
    endcase
  endfunction

  function automatic logic [EV_W-1:0] flt_need_m1(input logic [FLT_W-1:0] code);
    case (code)
      4'd0:                          flt_need_m1 = 3'd0;
      4'd1:                          flt_need_m1 = 3'd1;
      4'd2:                          flt_need_m1 = 3'd3;
      4'd10, 4'd13:                  flt_need_m1 = 3'd4;
      4'd4, 4'd6, 4'd8, 4'd11, 4'd14: flt_need_m1 = 3'd5;
      default:                       flt_need_m1 = 3'd7;
    endcase
  endfunction
endpackage

// File: rtl/etc_sync.sv
module etc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic d_async,
  output logic q_sync
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) chain[0] <= d_async;

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk) chain[i] <= chain[i-1];
  end

  assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/etc_prescale.sv
module etc_prescale
  import etc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             act_lvl,
  input  logic [PSC_W-1:0] code,
  output logic             psc_lvl
);
  localparam int NDIV  = (1 << PSC_W) - 1;
  localparam int CNT_W = NDIV;

  logic             act_d;
  logic [CNT_W-1:0] edge_cnt;
  logic [PSC_W-1:0] code_q;
  logic             code_chg;
  logic             act_rise;

  assign code_chg = (code != code_q);
  assign act_rise = act_lvl & ~act_d;

  // edge history keeps sampling during reset so the idle level settles
  always_ff @(posedge clk) act_d <= act_lvl;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      edge_cnt <= '0;
      code_q   <= '0;
    end else begin
      code_q <= code;
      if (code_chg)      edge_cnt <= '0;
      else if (act_rise) edge_cnt <= edge_cnt + 1'b1;
    end
  end

  always_comb begin
    psc_lvl = act_d;
    for (int i = 1; i <= NDIV; i++) begin
      if (int'(code) == i) psc_lvl = edge_cnt[i-1];
    end
  end

  p_clear_on_code_r4: assert property (@(posedge clk) disable iff (!rst_n)
    code_chg |=> (edge_cnt == '0));
endmodule

// File: rtl/etc_filter.sv
module etc_filter
  import etc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             smp_in,
  input  logic [FLT_W-1:0] code,
  output logic             flt_out
);
  localparam int DIV_W = MAX_SHIFT;

  logic [DIV_W-1:0] div_cnt;
  logic [DIV_W-1:0] div_max;
  logic [EV_W-1:0]  ev_cnt;
  logic [EV_W-1:0]  need_m1;
  logic [FLT_W-1:0] code_q;
  logic             code_chg;
  logic             tick;
  logic             out_q;

  assign need_m1  = flt_need_m1(code);
  assign div_max  = {DIV_W{1'b1}} >> (MAX_SHIFT - int'(flt_shift(code)));
  assign code_chg = (code != code_q);
  assign tick     = (div_cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_cnt <= '0;
      ev_cnt  <= '0;
      code_q  <= '0;
      out_q   <= 1'b0;
    end else begin
      code_q <= code;
      if (code_chg) begin
        div_cnt <= '0;
        ev_cnt  <= '0;
      end else begin
        div_cnt <= (div_cnt == div_max) ? '0 : div_cnt + 1'b1;
        if (tick) begin
          if (smp_in == out_q) begin
            ev_cnt <= '0;
          end else if (ev_cnt == need_m1) begin
            out_q  <= smp_in;
            ev_cnt <= '0;
          end else begin
            ev_cnt <= ev_cnt + 1'b1;
          end
        end
      end
    end
  end

  assign flt_out = out_q;

  p_move_on_tick_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(out_q));
  p_count_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !code_chg |-> (ev_cnt <= need_m1));
endmodule

// File: rtl/etc_edge.sv
module etc_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  input  logic en,
  output logic pulse
);
  logic lvl_d;

  always_ff @(posedge clk) begin
    if (!rst_n) lvl_d <= 1'b0;
    else        lvl_d <= lvl;
  end

  assign pulse = en & lvl & ~lvl_d;

  p_one_cycle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |=> !pulse);
endmodule

// File: rtl/ext_trig_cond.sv
module ext_trig_cond
  import etc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig_pin,
  input  logic             inv_pol,
  input  logic [PSC_W-1:0] psc_sel,
  input  logic [FLT_W-1:0] flt_sel,
  input  logic             ext_clk_en,
  output logic             trig_filt,
  output logic             cnt_en
);
  logic pin_s;
  logic act_lvl;
  logic psc_lvl;

  etc_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .d_async (trig_pin),
    .q_sync  (pin_s)
  );

  assign act_lvl = pin_s ^ inv_pol;

  etc_prescale u_psc (
    .clk     (clk),
    .rst_n   (rst_n),
    .act_lvl (act_lvl),
    .code    (psc_sel),
    .psc_lvl (psc_lvl)
  );

  etc_filter u_flt (
    .clk     (clk),
    .rst_n   (rst_n),
    .smp_in  (psc_lvl),
    .code    (flt_sel),
    .flt_out (trig_filt)
  );

  etc_edge u_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .lvl   (trig_filt),
    .en    (ext_clk_en),
    .pulse (cnt_en)
  );

  p_on_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_en |-> (trig_filt && !$past(trig_filt)));
  p_gated_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !ext_clk_en |-> !cnt_en);
endmodule

// File: tb/sim_ext_trig_cond.sv
module sim_ext_trig_cond;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       trig_pin = 1'b0;
  logic       inv_pol = 1'b0;
  logic [1:0] psc_sel = 2'd0;
  logic [3:0] flt_sel = 4'd0;
  logic       ext_clk_en = 1'b1;
  logic       trig_filt;
  logic       cnt_en;

  int total = 0;
  int bad = 0;
  int pcount = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  ext_trig_cond u0 (
    .clk(clk), .rst_n(rst_n), .trig_pin(trig_pin), .inv_pol(inv_pol),
    .psc_sel(psc_sel), .flt_sel(flt_sel), .ext_clk_en(ext_clk_en),
    .trig_filt(trig_filt), .cnt_en(cnt_en)
  );

  always @(negedge clk) if (rst_n && cnt_en) pcount++;

  function automatic int f_div(input int code);
    case (code)
      0, 1, 2, 3: return 1;
      4, 5:       return 2;
      6, 7:       return 4;
      8, 9:       return 8;
      10, 11, 12: return 16;
      default:    return 32;
    endcase
  endfunction

  function automatic int f_need(input int code);
    case (code)
      0:                  return 1;
      1:                  return 2;
      2:                  return 4;
      10, 13:             return 5;
      4, 6, 8, 11, 14:    return 6;
      default:            return 8;
    endcase
  endfunction

  function automatic int f_pulses(input int m, input int e);
    if (m == 1) return e;
    return (e + m / 2) / m;
  endfunction

  function automatic int f_level(input int m, input int e);
    if (m == 1) return 0;
    return ((e % m) >= m / 2) ? 1 : 0;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic restart(input bit inv, input int psc, input int flt, input bit en);
    @(negedge clk);
    rst_n = 1'b0;
    inv_pol = inv;
    psc_sel = psc[1:0];
    flt_sel = flt[3:0];
    ext_clk_en = en;
    trig_pin = inv;
    cycles(6);
    rst_n = 1'b1;
    cycles(2);
    pcount = 0;
  endtask

  task automatic pulse(input bit inv, input int hi, input int lo);
    trig_pin = ~inv;
    cycles(hi);
    trig_pin = inv;
    cycles(lo);
  endtask

  initial begin
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 190000) begin
        total++;
        bad++;
        $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 190000);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    int unsigned seed_v;
    seed_v = $urandom(32'h00c0ffee);

    // R1: reset state
    @(negedge clk);
    chk(trig_filt == 1'b0 && cnt_en == 1'b0, "R1 in reset", trig_filt, 0);
    restart(1'b0, 0, 0, 1'b1);
    cycles(10);
    chk(trig_filt == 1'b0, "R1 filt idle", trig_filt, 0);
    chk(pcount == 0, "R1 no pulse", pcount, 0);

    // R5 R6 R7: rise latency for every filter code
    for (int c = 0; c < 16; c++) begin
      int lat;
      int lo;
      int hi;
      restart(1'b0, 0, c, 1'b1);
      trig_pin = 1'b1;
      lat = 0;
      while (trig_filt == 1'b0 && lat < 1200) begin
        @(posedge clk);
        lat++;
        @(negedge clk);
      end
      lo = 4 + (f_need(c) - 1) * f_div(c);
      hi = 3 + f_need(c) * f_div(c);
      if (c == 0) chk(lat == 4, "R5 unfiltered latency", lat, 4);
      else if (f_div(c) == 1) chk(lat == 3 + f_need(c), "R6 full-rate latency", lat, 3 + f_need(c));
      else chk(lat >= lo && lat <= hi, "R7 rate/count latency", lat, hi);
      cycles(1);
      chk(pcount == 1, "R8 one strobe per rise", pcount, 1);
    end

    // R6: glitch one cycle shorter than N rejected, N cycles accepted
    restart(1'b0, 0, 3, 1'b1);
    pulse(1'b0, 7, 30);
    chk(pcount == 0 && trig_filt == 1'b0, "R6 short pulse rejected", pcount, 0);
    pulse(1'b0, 8, 30);
    chk(pcount == 1, "R6 N-cycle pulse accepted", pcount, 1);

    // R2: inverted polarity counts falling edges
    restart(1'b1, 0, 0, 1'b1);
    cycles(10);
    chk(pcount == 0 && trig_filt == 1'b0, "R2 inverted idle", pcount, 0);
    trig_pin = 1'b0;
    cycles(8);
    chk(trig_filt == 1'b1 && pcount == 1, "R2 falling edge active", pcount, 1);
    trig_pin = 1'b1;
    cycles(8);
    chk(trig_filt == 1'b0 && pcount == 1, "R2 rising edge inactive", pcount, 1);

    // R3: divide by 8 over 12 edges
    restart(1'b0, 3, 0, 1'b1);
    for (int k = 0; k < 12; k++) pulse(1'b0, 6, 6);
    cycles(10);
    chk(pcount == 2, "R3 div8 pulses", pcount, 2);
    chk(trig_filt == 1'b1, "R3 div8 level", trig_filt, 1);

    // R4: prescaler code change clears the edge count
    restart(1'b0, 2, 0, 1'b1);
    for (int k = 0; k < 3; k++) pulse(1'b0, 6, 6);
    cycles(10);
    chk(pcount == 1 && trig_filt == 1'b1, "R4 div4 before change", pcount, 1);
    psc_sel = 2'd1;
    cycles(10);
    chk(trig_filt == 1'b0, "R4 level cleared", trig_filt, 0);
    pulse(1'b0, 6, 6);
    cycles(10);
    chk(pcount == 2 && trig_filt == 1'b1, "R4 restart from zero", pcount, 2);

    // R9: disabled strobe, level still follows
    restart(1'b0, 0, 1, 1'b0);
    trig_pin = 1'b1;
    cycles(12);
    chk(trig_filt == 1'b1, "R9 level follows", trig_filt, 1);
    chk(pcount == 0, "R9 no strobe", pcount, 0);
    trig_pin = 1'b0;
    cycles(12);

    // R2 R3 R7 R8: constrained random pulse trains
    for (int s = 0; s < 12; s++) begin
      bit inv;
      int psc;
      int flt;
      int e;
      int m;
      int span;
      inv = 1'($urandom % 2);
      psc = int'($urandom % 4);
      flt = int'($urandom % 16);
      e = 1 + int'($urandom % 10);
      m = 1 << psc;
      span = f_div(flt) * (f_need(flt) + 2) + 4;
      restart(inv, psc, flt, 1'b1);
      for (int k = 0; k < e; k++)
        pulse(inv, span + int'($urandom % 8), span + int'($urandom % 8));
      cycles(span + 20);
      chk(pcount == f_pulses(m, e), "R8 random strobe count", pcount, f_pulses(m, e));
      chk(int'(trig_filt) == f_level(m, e), "R3 random final level", trig_filt, f_level(m, e));
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule